// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a four-beat burst. A start address is captured from outside; after that, every advance cycle steps a two-bit beat index, and the low two address bits are derived from the captured start bits and that index. The upper address bits come straight from the captured address and stay fixed for the whole burst.

Two orders are supported. Sequential order adds the beat index to the start bits modulo four. Interleaved order XORs the start bits with the beat index. The order select is not registered: it acts combinationally on the address output, so it is meant to be strapped or held steady. A single control pin chooses between loading (low) and advancing (high). A hold input freezes all state. A select input qualifies each load: a load taken while deselected ends the burst, and advance cycles then leave the address unchanged.

The interface is plain control and address pins. There is no data stream, so there is no valid/ready handshake and no back-pressure. The hold input is the only way to stall the block.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low, and until the first load after reset, addr_o is all zeros and busy_o is 0.
- R2: On a rising clock edge with hold_i=0 and adv_i=0, addr_i is captured and the beat index is cleared, so that after the edge addr_o equals addr_i. busy_o takes the value of sel_i.
- R3: With ilv_i=0 (sequential order), addr_o[1:0] equals (captured start bits + beat index) mod 4. Example: starting at 2, the sequence is 2,3,0,1.
- R4: With ilv_i=1 (interleaved order), addr_o[1:0] equals the captured start bits XOR the beat index. Example: starting at 1, the sequence is 1,0,3,2.
- R5: Each edge with hold_i=0, adv_i=1 and busy_o=1 steps the beat index by one. After the fourth beat it wraps to the first beat of the same four-address group.
- R6: addr_o[AW-1:2] changes only on a load edge. It never changes during advance or hold cycles.
- R7: On an edge with hold_i=1, addr_o and busy_o keep their values, whatever adv_i, sel_i and addr_i are, provided ilv_i is steady.
- R8: A change of ilv_i changes addr_o[1:0] between clock edges, with no edge needed.
- R9: After a load with sel_i=0, busy_o is 0 and advance edges leave addr_o unchanged until the next load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold_i | input | 1 | 1 freezes all state for this edge |
| adv_i | input | 1 | 0 loads addr_i, 1 advances the burst |
| sel_i | input | 1 | Select qualifying a load; 0 ends the burst |
| ilv_i | input | 1 | Order: 0 sequential, 1 interleaved (combinational) |
| addr_i | input | AW | External start address |
| addr_o | output | AW | Current beat address |
| busy_o | output | 1 | 1 while a selected burst is in progress |

## Verification
The hardest case to reach is a wrap that overlaps a hold or an order change. This happens when a hold lands on the fourth beat, or when ilv_i flips in the middle of a burst whose start bits are odd, the only case where the two orders disagree at beat 1. Directed bursts from starts 1 and 2 in both orders reach these points. A long random run follows, with loads weighted low so that bursts run past four beats, with frequent holds and deselected loads, and with occasional mid-cycle order toggles. Each run is compared with a reference model kept in the bench.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned BEAT_W = 2;
  localparam int unsigned BEATS  = 1 << BEAT_W;

  typedef logic [BEAT_W-1:0] beat_t;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;
endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
  parameter int unsigned AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] start_q
);
  import burst_pkg::*;
  localparam int unsigned UW = AW - BEAT_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= '0;
    else if (cap_en) start_q <= addr_in;
  end

  p_start_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(start_q));
  p_upper_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(start_q[AW-1:BEAT_W]));
  initial assert (UW > 0) else $error("AW too small");
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hold,
  input  logic                adv,
  input  logic                sel,
  output burst_pkg::beat_t    beat_q,
  output logic                busy_q
);
  import burst_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
      busy_q <= 1'b0;
    end else if (!hold) begin
      if (!adv) begin
        beat_q <= '0;
        busy_q <= sel;
      end else if (busy_q) begin
        beat_q <= beat_q + beat_t'(1);
      end
    end
  end

  p_load_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !adv) |=> (beat_q == '0));
  p_step_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && adv && busy_q) |=> (beat_q == beat_t'($past(beat_q) + 1)));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(beat_q) && $stable(busy_q)));
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && adv && !busy_q) |=> ($stable(beat_q) && !busy_q));
endmodule

// File: rtl/burst_order_mux.sv
module burst_order_mux (
  input  burst_pkg::beat_t  start_lo,
  input  burst_pkg::beat_t  beat,
  input  burst_pkg::order_e order,
  output burst_pkg::beat_t  addr_lo
);
  import burst_pkg::*;
  beat_t seq_lo;
  beat_t ilv_lo;

  assign seq_lo = start_lo + beat;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
    assign ilv_lo[b] = start_lo[b] ^ beat[b];
  end

  assign addr_lo = (order == ORD_ILV) ? ilv_lo : seq_lo;

  always_comb begin
    if (beat == '0) assert (addr_lo == start_lo);
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int unsigned AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_i,
  input  logic          adv_i,
  input  logic          sel_i,
  input  logic          ilv_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o,
  output logic          busy_o
);
  import burst_pkg::*;

  logic [AW-1:0] start_q;
  beat_t         beat_q;
  beat_t         lo_w;
  logic          cap_en;

  assign cap_en = !hold_i && !adv_i;

  burst_start_reg #(.AW(AW)) u_start (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (cap_en),
    .addr_in (addr_i),
    .start_q (start_q)
  );

  burst_beat_ctr u_beat (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (hold_i),
    .adv    (adv_i),
    .sel    (sel_i),
    .beat_q (beat_q),
    .busy_q (busy_o)
  );

  burst_order_mux u_order (
    .start_lo (start_q[BEAT_W-1:0]),
    .beat     (beat_q),
    .order    (order_e'(ilv_i)),
    .addr_lo  (lo_w)
  );

  assign addr_o = {start_q[AW-1:BEAT_W], lo_w};

  p_load_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (addr_o == $past(addr_i)));
  p_upper_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(addr_o[AW-1:BEAT_W]));
  p_idle_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !hold_i && adv_i && $stable(ilv_i)) |=> $stable(addr_o));
endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  localparam int AW = 20;
  localparam int WATCHDOG = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hold_i = 1'b0, adv_i = 1'b1, sel_i = 1'b0, ilv_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] addr_o;
  logic          busy_o;

  int checks = 0;
  int fails  = 0;
  logic [AW-1:0] m_start = '0;
  logic [1:0]    m_beat = '0;
  logic          m_busy = 1'b0;

  always #5 clk = ~clk;

  burst_addr_seq #(.AW(AW)) u_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .adv_i(adv_i),
    .sel_i(sel_i), .ilv_i(ilv_i), .addr_i(addr_i),
    .addr_o(addr_o), .busy_o(busy_o)
  );

  function automatic logic [1:0] exp_lo(logic [1:0] s, logic [1:0] b, logic ilv);
    return ilv ? (s ^ b) : 2'(s + b);
  endfunction

  function automatic logic [AW-1:0] exp_addr();
    return {m_start[AW-1:2], exp_lo(m_start[1:0], m_beat, ilv_i)};
  endfunction

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, addr_o, exp_addr());
    chk({req, " busy"}, AW'(busy_o), AW'(m_busy));
  endtask

  task automatic cyc(logic h, logic a, logic s, logic o, logic [AW-1:0] ad, string req);
    hold_i = h; adv_i = a; sel_i = s; ilv_i = o; addr_i = ad;
    @(posedge clk);
    if (!h) begin
      if (!a) begin m_start = ad; m_beat = 2'd0; m_busy = s; end
      else if (m_busy) m_beat = m_beat + 2'd1;
    end
    @(negedge clk);
    chk_all(req);
  endtask

  initial begin
    #(WATCHDOG * 10);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [AW-1:0] up;
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    chk_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 after reset");
    // R3 sequential from 2, wrap (R5)
    up = 20'hABCD0;
    cyc(0, 0, 1, 0, up | 20'd2, "R2 load");
    chk("R3 seq b0", AW'(addr_o[1:0]), AW'(2));
    cyc(0, 1, 1, 0, '0, "R3 seq");  chk("R3 b1", AW'(addr_o[1:0]), AW'(3));
    cyc(0, 1, 1, 0, '0, "R3 seq");  chk("R3 b2", AW'(addr_o[1:0]), AW'(0));
    cyc(0, 1, 1, 0, '0, "R3 seq");  chk("R3 b3", AW'(addr_o[1:0]), AW'(1));
    cyc(0, 1, 1, 0, '0, "R5 wrap"); chk("R5 wrap", AW'(addr_o[1:0]), AW'(2));
    chk("R6 upper", AW'(addr_o[AW-1:2]), AW'(up[AW-1:2]));
    // R4 interleaved from 1
    cyc(0, 0, 1, 1, 20'h12341, "R2 load ilv");
    cyc(0, 1, 1, 1, '0, "R4 ilv");  chk("R4 b1", AW'(addr_o[1:0]), AW'(0));
    // R8 order toggle mid-cycle: seq from 1 at beat1 gives 2
    #1 ilv_i = 1'b0; #1;
    chk("R8 toggle", AW'(addr_o[1:0]), AW'(2));
    cyc(0, 1, 1, 1, '0, "R4 ilv");  chk("R4 b2", AW'(addr_o[1:0]), AW'(3));
    // R7 hold
    cyc(1, 0, 1, 1, 20'hFFFFF, "R7 hold load");
    cyc(1, 1, 0, 1, 20'h55555, "R7 hold adv");
    chk("R7 b2 kept", AW'(addr_o[1:0]), AW'(3));
    cyc(0, 1, 1, 1, '0, "R4 ilv");  chk("R4 b3", AW'(addr_o[1:0]), AW'(2));
    // R9 deselected load
    cyc(0, 0, 0, 0, 20'h00777, "R9 desel load");
    cyc(0, 1, 1, 0, '0, "R9 no step");
    chk("R9 addr", addr_o, 20'h00777);
    chk("R9 busy", AW'(busy_o), AW'(0));
    // random
    for (int i = 0; i < 3000; i++) begin
      logic h, a, s, o;
      h = ($urandom % 5) == 0;
      a = ($urandom % 6) != 0;
      s = ($urandom % 4) != 0;
      o = ($urandom % 8) == 0 ? ~ilv_i : ilv_i;
      cyc(h, a, s, o, AW'($urandom), o ? "R4 R6 R7 rand" : "R3 R5 R9 rand");
      if (($urandom % 16) == 0) begin
        #1 ilv_i = ~ilv_i; #1;
        chk("R8 rand toggle", addr_o, exp_addr());
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule